// File: doc/BRIEF.md
# Run-Time Width Slice Steering Crossbar

The block sits in a memory datapath between the word-parallel side of the serial links and the storage array. The array side carries a word of sixteen 16-bit slices. The external side carries up to sixteen 16-bit lanes. A 3-bit width code chooses how many external lanes are active: 1, 2, 4, 8 or 16.

The upper bits of a 4-bit subcolumn address choose which aligned group of slices the active lanes reach. On the read path, the selected slices are packed onto the lowest external lanes. On the write path, the external lanes are scattered onto the selected slices, and a per-slice write-enable mask is raised for those slices only.

Both paths are registered. They update one cycle after an input valid strobe, and an output valid strobe goes with them. A width code the block does not support is steered as full width, and an error flag is raised.

Top module: `lane_steer_xbar`

## Requirements
- R1: The width code maps to the active lane count as follows: 000 gives 1 lane, 001 gives 2, 010 gives 4, 011 gives 8 and 100 gives 16. The selected group is the aligned block of that many slices whose index is `sub_col` with its low log2(lanes) bits cleared.
- R2: At code 100 the subcolumn address has no effect. Every read lane j carries slice j, every slice i receives write lane i, and all 16 mask bits are set.
- R3: At code 011, `sub_col[3]`=0 connects slices 7..0 to lanes 7..0, and `sub_col[3]`=1 connects slices 15..8 to lanes 7..0.
- R4: At code 010, `sub_col[3:2]` chooses slices 4k+3..4k, where k is that 2-bit value, on lanes 3..0.
- R5: At code 001, `sub_col[3:1]` chooses slices 2k+1..2k, where k is that 3-bit value, on lanes 1..0.
- R6: At code 000, slice number `sub_col` is carried on lane 0 in both directions.
- R7: Read lanes at or above the active lane count are driven to zero.
- R8: Write mask bits are set only for the selected slices. A selected slice receives the write lane that matches its position within the group. Unselected slices carry zero data.
- R9: Codes 101, 110 and 111 are steered exactly as code 100, and `cfg_err` is set. With `NARROW_OK`=0, codes 000 and 001 are also handled this way. Legal codes leave `cfg_err` clear.
- R10: Outputs are loaded on the first rising edge after `in_valid`=1, and `out_valid` follows `in_valid` by one cycle. A cycle without `in_valid` clears `wr_mask` and leaves `rd_lanes`, `wr_word` and `cfg_err` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Transfer request strobe |
| width_code | input | 3 | Device width selection |
| sub_col | input | 4 | Subcolumn address |
| array_word | input | 256 | Slices read from the array, slice i at bits 16i+15:16i |
| wr_lanes | input | 256 | External write lanes, lane j at bits 16j+15:16j |
| out_valid | output | 1 | Outputs updated this cycle |
| rd_lanes | output | 256 | Packed external read lanes |
| wr_word | output | 256 | Write data steered onto array slices |
| wr_mask | output | 16 | Per-slice write enable |
| cfg_err | output | 1 | Width code was reserved or unsupported |

## Verification
The assertions assume a clean reset. They also assume that `width_code` and `sub_col` are stable for the whole cycle in which `in_valid` is sampled. The mask population and upper-lane checks rely on this, because they compare registered outputs with the registered lane count.

The stimulus changes inputs only on falling clock edges. It sweeps all 128 code and address pairs with fresh random slice data on every beat, and runs the sweep on a second instance built without narrow-width support. Idle beats put different data on the inputs to show that the held outputs do not move.

// File: rtl/steer_pkg.sv
package steer_pkg;
  // log2 of the active lane count for a width code; unsupported codes give full_lg
  function automatic int unsigned lanes_log2(input logic [2:0] code,
                                             input bit narrow_ok,
                                             input int unsigned full_lg);
    int unsigned r;
    case (code)
      3'd0:    r = narrow_ok ? 0 : full_lg;
      3'd1:    r = narrow_ok ? 1 : full_lg;
      3'd2:    r = 2;
      3'd3:    r = 3;
      default: r = full_lg;
    endcase
    return (r > full_lg) ? full_lg : r;
  endfunction

  function automatic bit code_legal(input logic [2:0] code, input bit narrow_ok);
    case (code)
      3'd0, 3'd1:       return narrow_ok;
      3'd2, 3'd3, 3'd4: return 1'b1;
      default:          return 1'b0;
    endcase
  endfunction

  // first slice of the aligned group holding sub-column sc
  function automatic int unsigned group_base(input int unsigned sc, input int unsigned lg);
    return (sc >> lg) << lg;
  endfunction
endpackage

// File: rtl/steer_decode.sv
module steer_decode #(
  parameter int SC_W      = 4,
  parameter int LG_W      = 3,
  parameter bit NARROW_OK = 1'b1
) (
  input  logic [2:0]      width_code,
  input  logic [SC_W-1:0] sub_col,
  output logic [LG_W-1:0] lane_lg,
  output logic [SC_W-1:0] grp_base,
  output logic            bad_code
);
  int unsigned lg_i;

  always_comb begin
    lg_i     = steer_pkg::lanes_log2(width_code, NARROW_OK, SC_W);
    lane_lg  = LG_W'(lg_i);
    grp_base = SC_W'(steer_pkg::group_base(int'(sub_col), lg_i));
    bad_code = !steer_pkg::code_legal(width_code, NARROW_OK);
  end

  // R9: an illegal code always decodes to the full word
  always_comb begin
    if (bad_code) begin
      p_bad_is_full_r9: assert (lg_i == SC_W);
    end
  end
endmodule

// File: rtl/steer_read.sv
module steer_read #(
  parameter int SLICE_W = 16,
  parameter int NSLICE  = 16,
  parameter int SC_W    = 4,
  parameter int LG_W    = 3,
  localparam int BUS_W  = SLICE_W * NSLICE
) (
  input  logic [BUS_W-1:0] array_word,
  input  logic [LG_W-1:0]  lane_lg,
  input  logic [SC_W-1:0]  grp_base,
  output logic [BUS_W-1:0] lanes_out
);
  for (genvar j = 0; j < NSLICE; j++) begin : g_lane
    int unsigned src;
    logic        active;
    always_comb begin
      src    = int'(grp_base) + j;
      active = (j < (1 << lane_lg)) && (src < NSLICE);
      lanes_out[j*SLICE_W +: SLICE_W] =
        active ? array_word[src*SLICE_W +: SLICE_W] : '0;
    end
  end
endmodule

// File: rtl/steer_write.sv
module steer_write #(
  parameter int SLICE_W = 16,
  parameter int NSLICE  = 16,
  parameter int SC_W    = 4,
  parameter int LG_W    = 3,
  localparam int BUS_W  = SLICE_W * NSLICE
) (
  input  logic [BUS_W-1:0]  lanes_in,
  input  logic [LG_W-1:0]   lane_lg,
  input  logic [SC_W-1:0]   grp_base,
  output logic [BUS_W-1:0]  slice_word,
  output logic [NSLICE-1:0] slice_en
);
  for (genvar i = 0; i < NSLICE; i++) begin : g_slice
    int unsigned pos;
    always_comb begin
      pos         = i - int'(grp_base);
      slice_en[i] = (i >= int'(grp_base)) && (pos < (1 << lane_lg));
      slice_word[i*SLICE_W +: SLICE_W] =
        slice_en[i] ? lanes_in[pos*SLICE_W +: SLICE_W] : '0;
    end
  end
endmodule

// File: rtl/lane_steer_xbar.sv
module lane_steer_xbar #(
  parameter int SLICE_W   = 16,
  parameter int NSLICE    = 16,
  parameter bit NARROW_OK = 1'b1,
  localparam int SC_W     = $clog2(NSLICE),
  localparam int LG_W     = $clog2(SC_W + 1),
  localparam int BUS_W    = SLICE_W * NSLICE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [2:0]        width_code,
  input  logic [SC_W-1:0]   sub_col,
  input  logic [BUS_W-1:0]  array_word,
  input  logic [BUS_W-1:0]  wr_lanes,
  output logic              out_valid,
  output logic [BUS_W-1:0]  rd_lanes,
  output logic [BUS_W-1:0]  wr_word,
  output logic [NSLICE-1:0] wr_mask,
  output logic              cfg_err
);
  logic [LG_W-1:0]   lane_lg;
  logic [SC_W-1:0]   grp_base;
  logic              bad_code;
  logic [BUS_W-1:0]  rd_next, wr_next;
  logic [NSLICE-1:0] en_next;
  logic [LG_W-1:0]   lg_q;

  steer_decode #(.SC_W(SC_W), .LG_W(LG_W), .NARROW_OK(NARROW_OK)) u_dec (
    .width_code(width_code), .sub_col(sub_col),
    .lane_lg(lane_lg), .grp_base(grp_base), .bad_code(bad_code));

  steer_read #(.SLICE_W(SLICE_W), .NSLICE(NSLICE), .SC_W(SC_W), .LG_W(LG_W)) u_rd (
    .array_word(array_word), .lane_lg(lane_lg), .grp_base(grp_base),
    .lanes_out(rd_next));

  steer_write #(.SLICE_W(SLICE_W), .NSLICE(NSLICE), .SC_W(SC_W), .LG_W(LG_W)) u_wr (
    .lanes_in(wr_lanes), .lane_lg(lane_lg), .grp_base(grp_base),
    .slice_word(wr_next), .slice_en(en_next));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      rd_lanes  <= '0;
      wr_word   <= '0;
      wr_mask   <= '0;
      cfg_err   <= 1'b0;
      lg_q      <= '0;
    end else begin
      out_valid <= in_valid;
      wr_mask   <= in_valid ? en_next : '0;
      if (in_valid) begin
        rd_lanes <= rd_next;
        wr_word  <= wr_next;
        cfg_err  <= bad_code;
        lg_q     <= lane_lg;
      end
    end
  end

  // R10: output strobe trails the request by one cycle
  p_valid_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R10: no write enables and no read data change on idle cycles
  p_idle_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (wr_mask == '0));
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(rd_lanes));
  // R8: mask population equals the active lane count
  p_mask_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(wr_mask) == (1 << lg_q)));
  // R7: nothing above the active lanes
  p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((rd_lanes >> (SLICE_W << lg_q)) == '0));
  // R9: an error beat writes the full word
  p_err_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cfg_err) |-> (&wr_mask));
endmodule

// File: tb/lane_steer_xbar_test.sv
module lane_steer_xbar_test;
  localparam int SW = 16;
  localparam int NS = 16;
  localparam int BW = SW * NS;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [2:0]    width_code = '0;
  logic [3:0]    sub_col = '0;
  logic [BW-1:0] array_word = '0, wr_lanes = '0;
  logic          out_valid, out_valid_n;
  logic [BW-1:0] rd_lanes, wr_word, rd_lanes_n, wr_word_n;
  logic [NS-1:0] wr_mask, wr_mask_n;
  logic          cfg_err, cfg_err_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  lane_steer_xbar uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .width_code(width_code),
    .sub_col(sub_col), .array_word(array_word), .wr_lanes(wr_lanes),
    .out_valid(out_valid), .rd_lanes(rd_lanes), .wr_word(wr_word),
    .wr_mask(wr_mask), .cfg_err(cfg_err));

  lane_steer_xbar #(.NARROW_OK(1'b0)) uut_n (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .width_code(width_code),
    .sub_col(sub_col), .array_word(array_word), .wr_lanes(wr_lanes),
    .out_valid(out_valid_n), .rd_lanes(rd_lanes_n), .wr_word(wr_word_n),
    .wr_mask(wr_mask_n), .cfg_err(cfg_err_n));

  function automatic int lane_count(input logic [2:0] code, input bit narrow);
    case (code)
      3'd0: return narrow ? 1 : 16;
      3'd1: return narrow ? 2 : 16;
      3'd2: return 4;
      3'd3: return 8;
      default: return 16;
    endcase
  endfunction

  function automatic bit is_bad(input logic [2:0] code, input bit narrow);
    return (code > 3'd4) || (!narrow && code < 3'd2);
  endfunction

  function automatic logic [BW-1:0] rand_word();
    logic [BW-1:0] w;
    for (int k = 0; k < BW / 32; k++) w[k*32 +: 32] = $urandom;
    return w;
  endfunction

  task automatic check_vec(input string req, input logic [BW-1:0] act,
                           input logic [BW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // expected outputs: the group is the sub-column's block of n slices
  task automatic check_beat(input bit narrow, input logic [BW-1:0] q,
                            input logic [BW-1:0] w, input logic [NS-1:0] m,
                            input logic e, input logic v);
    int n, first;
    logic [BW-1:0] eq, ew;
    logic [NS-1:0] em;
    string tag;
    n = lane_count(width_code, narrow);
    first = (int'(sub_col) / n) * n;
    eq = '0; ew = '0; em = '0;
    for (int j = 0; j < n; j++) begin
      eq[j*SW +: SW] = array_word[(first+j)*SW +: SW];
      ew[(first+j)*SW +: SW] = wr_lanes[j*SW +: SW];
      em[first+j] = 1'b1;
    end
    case (n)
      1: tag = "R6";
      2: tag = "R5";
      4: tag = "R4";
      8: tag = "R3";
      default: tag = "R2";
    endcase
    if (is_bad(width_code, narrow)) tag = "R9";
    check_vec({tag, "/R1/R7 read lanes"}, q, eq);
    check_vec({tag, "/R8 write word"}, w, ew);
    check_vec({tag, "/R8 write mask"}, BW'(m), BW'(em));
    check_vec("R9 error flag", BW'(e), BW'(is_bad(width_code, narrow)));
    check_vec("R10 out_valid", BW'(v), BW'(1));
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [BW-1:0] held;
    repeat (3) @(negedge clk);
    // reset state
    check_vec("R10 reset out_valid", BW'(out_valid), '0);
    check_vec("R10 reset mask", BW'(wr_mask), '0);
    check_vec("R10 reset read lanes", rd_lanes, '0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int c = 0; c < 8; c++) begin
      for (int s = 0; s < 16; s++) begin
        width_code = 3'(c);
        sub_col    = 4'(s);
        array_word = rand_word();
        wr_lanes   = rand_word();
        in_valid   = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check_beat(1'b1, rd_lanes, wr_word, wr_mask, cfg_err, out_valid);
        check_beat(1'b0, rd_lanes_n, wr_word_n, wr_mask_n, cfg_err_n, out_valid_n);
      end
    end

    // R10: idle beat with different inputs must not move held outputs
    held = rd_lanes;
    in_valid   = 1'b0;
    width_code = 3'd0;
    sub_col    = 4'd3;
    array_word = rand_word();
    wr_lanes   = rand_word();
    @(posedge clk);
    @(negedge clk);
    check_vec("R10 idle out_valid", BW'(out_valid), '0);
    check_vec("R10 idle mask cleared", BW'(wr_mask), '0);
    check_vec("R10 idle read hold", rd_lanes, held);
    check_vec("R10 idle err hold", BW'(cfg_err), BW'(1));

    done = 1'b1;
    summary();
  end
endmodule